// File: doc/BRIEF.md
# Strobe-Latched 1K x 1 Static Memory

This block is a 1024-word by 1-bit static memory that is reached through a strobed interface. A 10-bit address, a single-bit data input, a single-bit data output, an active-low enable strobe, an active-low write control and two active-low device selects make up the interface. When the enable strobe goes low, the block captures the address into an internal register. It then runs one access against a 32 x 32 cell matrix. The upper five address bits pick the row and the lower five bits pick the column.

Reads pass through an output data latch. The latch follows the addressed cell while the access is active and holds its last value once the strobe returns high. A separate output-enable signal stands in for a three-state driver, so the data line can be shared across a larger array. One system clock samples every strobe. The strobe sequencing is held in a three-state machine:
- `ST_LOCKED`: the reset state. The block waits until it samples the enable high.
- `ST_STANDBY`: the block is idle and waits for the enable to fall.
- `ST_ACTIVE`: the address is frozen and the access is in progress.

The transitions are `LOCKED->STANDBY` (enable sampled high), `STANDBY->ACTIVE` (enable sampled low, which captures the address) and `ACTIVE->STANDBY` (enable sampled high).

Top module: `strobe_ram_1kx1`

## Requirements
- R1: Each of the 1024 locations keeps its own bit. The row is addr[9:5] and the column is addr[4:0].
- R2: The address is captured at the first clock edge at which `en_n` is sampled low in standby. Later changes of `addr` have no effect until `en_n` has been sampled high and then low again.
- R3: After reset, the block ignores a low `en_n` until it has sampled `en_n` high at least once.
- R4: At every clock edge of the active period where `wr_n` is low and both selects are low, `din` is stored at the captured address.
- R5: If either select is high, no write takes place, whatever the state of `wr_n`.
- R6: `dout_oe` is 1 only in the active period with `wr_n` high and both selects low. It is therefore 0 during every write.
- R7: In the active period, from the cycle after the capture edge onward, `dout` shows the stored bit at the captured address.
- R8: After `en_n` returns high, `dout` holds the last bit loaded by the latch. The latch loads at each edge of the active period where `wr_n` is high.
- R9: While reset is asserted and after it is released, `dout_oe` is 0 and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| en_n | input | 1 | Active-low enable strobe; its falling edge captures the address |
| wr_n | input | 1 | Active-low write control |
| sel_a_n | input | 1 | First active-low device select |
| sel_b_n | input | 1 | Second active-low device select |
| addr | input | 10 | Word address: row in [9:5], column in [4:0] |
| din | input | 1 | Write data |
| dout | output | 1 | Latched read data |
| dout_oe | output | 1 | Output drive enable; 0 means high impedance |

## Verification
Some behaviours are checked by assertions on every cycle:
- the captured address stays frozen through the active period;
- the active period only starts from standby after a low enable sample;
- the output enable appears only after a low enable sample;
- the latch output stays still while the block is idle;
- a written cell reads back its new bit.

Other behaviours can only be shown by the bench's scenarios:
- row and column decoding across corner addresses;
- that writes with a select high leave the cell untouched;
- that address changes after capture are ignored;
- the lock-out of an enable that is already low when reset ends.

// File: rtl/strobe_ram_pkg.sv
package strobe_ram_pkg;
    typedef enum logic [1:0] {
        ST_LOCKED  = 2'd0,
        ST_STANDBY = 2'd1,
        ST_ACTIVE  = 2'd2
    } strobe_state_t;
endpackage

// File: rtl/strobe_ctrl.sv
module strobe_ctrl
    import strobe_ram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              active,
    output logic [ADDR_W-1:0] addr_q
);
    strobe_state_t state, state_nx;
    logic          capture;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOCKED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOCKED:  if (en_n)  state_nx = ST_STANDBY;
            ST_STANDBY: if (!en_n) state_nx = ST_ACTIVE;
            ST_ACTIVE:  if (en_n)  state_nx = ST_STANDBY;
            default:               state_nx = ST_LOCKED;
        endcase
    end

    // outputs of the machine
    always_comb begin
        active  = 1'b0;
        capture = 1'b0;
        unique case (state)
            ST_LOCKED:  ;
            ST_STANDBY: capture = !en_n;
            ST_ACTIVE:  active  = 1'b1;
            default:    ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (capture) addr_q <= addr;
    end

    // R2: address frozen for the whole active period
    a_r2_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable(addr_q));

    // R3: active period only entered from standby after a low enable sample
    a_r3_entry_from_standby: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> ($past(state == ST_STANDBY) && !$past(en_n)));
endmodule

// File: rtl/cell_matrix.sv
module cell_matrix #(
    parameter int ROW_BITS = 5,
    parameter int COL_BITS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ROW_BITS-1:0] row,
    input  logic [COL_BITS-1:0] col,
    input  logic                wr_bit,
    output logic                rd_bit
);
    localparam int ROWS = 1 << ROW_BITS;
    localparam int COLS = 1 << COL_BITS;

    logic [COLS-1:0] row_data [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (wr_en && (row == ROW_BITS'(r)))
                row_data[r][col] <= wr_bit;
        end
    end

    assign rd_bit = row_data[row][col];

    // R4: a written cell reads back its new bit
    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && $stable(row) && $stable(col)) |-> (rd_bit == $past(wr_bit)));
endmodule

// File: rtl/out_latch.sv
module out_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic transparent,
    input  logic cell_bit,
    output logic dout
);
    logic held_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    held_q <= 1'b0;
        else if (load) held_q <= cell_bit;
    end

    assign dout = transparent ? cell_bit : held_q;

    // R8: output holds still while the block is idle
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!transparent && !$past(transparent)) |-> $stable(dout));
endmodule

// File: rtl/strobe_ram_1kx1.sv
module strobe_ram_1kx1 #(
    parameter int ROW_BITS = 5,
    parameter int COL_BITS = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en_n,
    input  logic                         wr_n,
    input  logic                         sel_a_n,
    input  logic                         sel_b_n,
    input  logic [ROW_BITS+COL_BITS-1:0] addr,
    input  logic                         din,
    output logic                         dout,
    output logic                         dout_oe
);
    localparam int ADDR_W = ROW_BITS + COL_BITS;

    logic              active;
    logic [ADDR_W-1:0] addr_q;
    logic              selected;
    logic              wr_en;
    logic              cell_bit;

    strobe_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_n   (en_n),
        .addr   (addr),
        .active (active),
        .addr_q (addr_q)
    );

    assign selected = !sel_a_n && !sel_b_n;
    assign wr_en    = active && !wr_n && selected;
    assign dout_oe  = active && wr_n && selected;

    cell_matrix #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_cells (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .row    (addr_q[ADDR_W-1:COL_BITS]),
        .col    (addr_q[COL_BITS-1:0]),
        .wr_bit (din),
        .rd_bit (cell_bit)
    );

    out_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (active && wr_n),
        .transparent (active),
        .cell_bit    (cell_bit),
        .dout        (dout)
    );

    // R6: output drive only after the enable was sampled low
    a_r6_oe_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> !$past(en_n));
endmodule

// File: tb/tb_strobe_ram_1kx1.sv
module tb_strobe_ram_1kx1;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       sel_a_n = 1'b0;
    logic       sel_b_n = 1'b0;
    logic [9:0] addr = '0;
    logic       din = 1'b0;
    logic       dout;
    logic       dout_oe;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    strobe_ram_1kx1 dut (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .wr_n(wr_n),
        .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .addr(addr),
        .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    // {address, data}: row/column corners and mixed patterns (R1)
    localparam logic [10:0] VEC [8] = '{
        {10'd0,    1'b1}, {10'd1023, 1'b1}, {10'd31,  1'b0}, {10'd32,  1'b1},
        {10'd992,  1'b0}, {10'h155,  1'b1}, {10'h2AA, 1'b0}, {10'd33,  1'b1}
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic write_cycle(input logic [9:0] a, input logic [9:0] a_late,
                               input logic d, input logic sa, input logic sb);
        @(negedge clk); en_n = 1'b1; wr_n = 1'b1; addr = a; din = d;
        sel_a_n = sa; sel_b_n = sb;
        @(negedge clk); en_n = 1'b0;
        @(negedge clk); wr_n = 1'b0; addr = a_late;
        @(negedge clk); check("R6 no drive during write", dout_oe, 1'b0);
        wr_n = 1'b1; en_n = 1'b1; sel_a_n = 1'b0; sel_b_n = 1'b0;
    endtask

    task automatic read_cycle(input string req, input logic [9:0] a, input logic exp);
        @(negedge clk); en_n = 1'b1; wr_n = 1'b1; addr = a;
        @(negedge clk); en_n = 1'b0;
        @(negedge clk); check({req, " R7 read data"}, dout, exp);
        check("R6 drive on read", dout_oe, 1'b1);
        addr = ~a;
        @(negedge clk); check({req, " R2 late address ignored"}, dout, exp);
        en_n = 1'b1;
        @(negedge clk); check("R8 hold after enable rises", dout, exp);
        check("R6 idle no drive", dout_oe, 1'b0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9 reset oe", dout_oe, 1'b0);
        check("R9 reset data", dout, 1'b0);

        // R3: enable already low when reset ends is not accepted
        en_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R3 locked no drive", dout_oe, 1'b0);
        en_n = 1'b1;
        @(negedge clk);

        // table walk: write every vector, then read all back (R1, R4, R7)
        for (int i = 0; i < 8; i++)
            write_cycle(VEC[i][10:1], VEC[i][10:1], VEC[i][0], 1'b0, 1'b0);
        for (int i = 0; i < 8; i++)
            read_cycle("R1 R4", VEC[i][10:1], VEC[i][0]);

        // R5: writes with a select high do not land
        write_cycle(10'd0, 10'd0, 1'b0, 1'b1, 1'b0);
        write_cycle(10'd0, 10'd0, 1'b0, 1'b0, 1'b1);
        read_cycle("R5", 10'd0, 1'b1);

        // R6: read with one select high is not driven
        @(negedge clk); sel_b_n = 1'b1; addr = 10'd1023;
        @(negedge clk); en_n = 1'b0;
        @(negedge clk); check("R6 deselected read", dout_oe, 1'b0);
        en_n = 1'b1; sel_b_n = 1'b0;

        // R2: address changed after capture; the write goes to the captured one
        write_cycle(10'd500, 10'd501, 1'b1, 1'b0, 1'b0);
        write_cycle(10'd501, 10'd501, 1'b0, 1'b0, 1'b0);
        write_cycle(10'd500, 10'd501, 1'b1, 1'b0, 1'b0);
        read_cycle("R2", 10'd501, 1'b0);
        read_cycle("R2", 10'd500, 1'b1);

        // R8: hold changes only with a new read
        read_cycle("R8", 10'd31, 1'b0);
        repeat (4) @(negedge clk);
        check("R8 long hold", dout, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule